// File: doc/BRIEF.md
# Shared-Ramp Multichannel Code Capture Controller

This block sequences a single-slope (Wilkinson) conversion for a bank of channels that share one analogue ramp and one 12-bit count. Each channel holds two stored analogue levels, a charge sample and a fine-time sample. Each level is compared against the common ramp by its own comparator. A start request clears the count and pulses a ramp reset. The count then advances once per clock from 0 up to full scale. Every comparator that switches during that sweep gets the count value of the cycle in which it switched, and that value becomes the channel's digital code.

Comparator outputs come from the analogue side and are asynchronous to the clock. Each one passes through a two-flop synchronizer and a rising-edge detector. The count fed to the capture registers is delayed by the same number of stages, so a code equals the count shown in the cycle in which the comparator rose. Only channels marked as hit in the mask sampled at start take part. When the last delayed count has been examined, a one-cycle done strobe marks the codes as final.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and ramp_rst_o are low and every code output is zero.
- R2: A start_i sampled high while the block is idle is accepted. ramp_rst_o is high for exactly one cycle, the cycle after the accepting edge (cycle 0). busy_o is high from cycle 0 through cycle 4097 and low in cycle 4098.
- R3: The count shows value k in cycle k (k = 0..4095). A comparator of a hit channel that first rises during cycle k yields code k. Channel i's charge code sits in code_q_o[12*i+11:12*i] and its fine-time code in code_t_o[12*i+11:12*i]. All 32 inputs are captured independently.
- R4: Only the first rising edge after an accepted start is captured. Later toggles in the same sweep, and any toggles after done, leave the code unchanged.
- R5: A hit input with no rising edge during cycles 0..4095 gets code 4095. This covers an input that never rises, an input that rises at cycle 4096 or later, and an input that is already high before start.
- R6: A channel whose hit_mask_i bit is low at the accepting edge has both codes equal to 0 after that start, whatever its comparators do.
- R7: done_o is high for exactly one cycle, cycle 4098. At that point all codes are final, and they hold until the next accepted start.
- R8: A start_i that arrives while busy_o is high is ignored. This includes the two flush cycles after the count stops. No ramp reset is issued and the running conversion's timing and codes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled each edge |
| hit_mask_i | input | 16 | Channels to convert, sampled at the accepting edge |
| cmp_q_i | input | 16 | Charge comparators, one per channel, asynchronous |
| cmp_t_i | input | 16 | Fine-time comparators, one per channel, asynchronous |
| ramp_rst_o | output | 1 | One-cycle ramp reset at conversion start |
| busy_o | output | 1 | Conversion or flush in progress |
| done_o | output | 1 | One-cycle strobe, codes final |
| code_q_o | output | 192 | Charge codes, 12 bits per channel |
| code_t_o | output | 192 | Fine-time codes, 12 bits per channel |

## Verification
The bench counts cycles from the edge that accepts start. In cycle c it drives each comparator to the level it should have during count c, then samples at the falling edge. It expects ramp_rst_o only in cycle 0, busy_o through cycle 4097 and done_o only in cycle 4098. The codes are compared in cycle 4098, because the last capture lands on that cycle's opening edge after three register stages (two synchronizer flops plus the capture flop). After 24 further cycles of toggling all comparators, the codes are compared again. Sweeps cover edge positions 0 and 4095, a position past full scale, inputs that are high before start, masked channels, repeated toggles, and start requests placed in mid-sweep and in the flush window.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int unsigned DEF_N_CH   = 16;
  localparam int unsigned DEF_CODE_W = 12;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/wcc_sync_edge.sv
module wcc_sync_edge #(
  parameter int unsigned STAGES = wcc_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop for edge detection
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], d_i};
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/wcc_seq.sv
module wcc_seq #(
  parameter int unsigned CODE_W = wcc_pkg::DEF_CODE_W,
  parameter int unsigned SYNC   = wcc_pkg::DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              clr_o,
  output logic              ramp_rst_o,
  output logic              busy_o,
  output logic              act_o,
  output logic              done_o,
  output logic [CODE_W-1:0] cnt_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  logic                         run_q;
  logic [CODE_W-1:0]            cnt_q;
  logic [SYNC-1:0]              act_sr_q;
  logic [SYNC-1:0][CODE_W-1:0]  cnt_sr_q;
  logic                         ramp_q, done_q;
  logic                         idle, accept;

  assign idle   = ~run_q & ~(|act_sr_q);
  assign accept = start_i & idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      act_sr_q <= '0;
      cnt_sr_q <= '0;
      ramp_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ramp_q   <= accept;
      // strobe when the last delayed window stage falls
      done_q   <= act_sr_q[SYNC-1] & ~act_sr_q[SYNC-2];
      act_sr_q <= {act_sr_q[SYNC-2:0], run_q};
      cnt_sr_q <= {cnt_sr_q[SYNC-2:0], cnt_q};
      if (accept) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == FULL) run_q <= 1'b0;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clr_o      = accept;
  assign ramp_rst_o = ramp_q;
  assign busy_o     = run_q | (|act_sr_q);
  assign act_o      = act_sr_q[SYNC-1];
  assign cnt_o      = cnt_sr_q[SYNC-1];
  assign done_o     = done_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != FULL && !accept) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_STOP_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(cnt_q) == FULL); // R2
endmodule

// File: rtl/wcc_code_latch.sv
module wcc_code_latch #(
  parameter int unsigned CODE_W = wcc_pkg::DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              act_i,
  input  logic              rise_i,
  input  logic [CODE_W-1:0] cnt_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  logic              en_q, got_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      got_q  <= 1'b0;
      code_q <= '0;
    end else if (clr_i) begin
      en_q   <= en_i;
      got_q  <= 1'b0;
      code_q <= en_i ? FULL : '0;  // full scale unless an edge is seen
    end else if (en_q && !got_q && act_i && rise_i) begin
      got_q  <= 1'b1;
      code_q <= cnt_i;
    end
  end

  assign code_o = code_q;

  AST_FIRST_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_q && !clr_i) |=> $stable(code_q)); // R4
  AST_MASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> code_q == '0); // R6
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
  parameter int unsigned N_CH   = wcc_pkg::DEF_N_CH,
  parameter int unsigned CODE_W = wcc_pkg::DEF_CODE_W,
  parameter int unsigned SYNC   = wcc_pkg::DEF_SYNC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_CH-1:0]          hit_mask_i,
  input  logic [N_CH-1:0]          cmp_q_i,
  input  logic [N_CH-1:0]          cmp_t_i,
  output logic                     ramp_rst_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [N_CH*CODE_W-1:0]   code_q_o,
  output logic [N_CH*CODE_W-1:0]   code_t_o
);
  logic              clr, act;
  logic [CODE_W-1:0] cnt_d;

  wcc_seq #(.CODE_W(CODE_W), .SYNC(SYNC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .clr_o      (clr),
    .ramp_rst_o (ramp_rst_o),
    .busy_o     (busy_o),
    .act_o      (act),
    .done_o     (done_o),
    .cnt_o      (cnt_d)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic rise_q, rise_t;

    wcc_sync_edge #(.STAGES(SYNC)) u_sync_q (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_q_i[i]), .rise_o(rise_q));
    wcc_sync_edge #(.STAGES(SYNC)) u_sync_t (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_t_i[i]), .rise_o(rise_t));

    wcc_code_latch #(.CODE_W(CODE_W)) u_lat_q (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .en_i(hit_mask_i[i]),
      .act_i(act), .rise_i(rise_q), .cnt_i(cnt_d),
      .code_o(code_q_o[i*CODE_W +: CODE_W]));
    wcc_code_latch #(.CODE_W(CODE_W)) u_lat_t (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .en_i(hit_mask_i[i]),
      .act_i(act), .rise_i(rise_t), .cnt_i(cnt_d),
      .code_o(code_t_o[i*CODE_W +: CODE_W]));
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !ramp_rst_o); // R8
  AST_RAMP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_rst_o |=> !ramp_rst_o); // R2
endmodule

// File: tb/tb_wilk_conv_ctrl.sv
module tb_wilk_conv_ctrl;
  localparam int N = 16;
  localparam int W = 12;
  localparam int FULL = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] hit = '0, cq = '0, ct = '0;
  logic ramp, busy, done;
  logic [N*W-1:0] code_q, code_t;

  int checks = 0;
  int errors = 0;

  int  kq[N], kt[N];
  bit  pre_q[N], pre_t[N];
  bit  glitch;
  bit  mid_start;

  always #5 clk = ~clk;

  wilk_conv_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hit_mask_i(hit),
    .cmp_q_i(cq), .cmp_t_i(ct), .ramp_rst_o(ramp), .busy_o(busy),
    .done_o(done), .code_q_o(code_q), .code_t_o(code_t));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic in_val(int k, bit pre, int c);
    if (pre) return 1'b1;
    if (k < 0 || c < k) return 1'b0;
    if (glitch) return ((c - k) % 4) < 2;
    return 1'b1;
  endfunction

  function automatic int exp_code(bit h, int k, bit pre);
    if (!h) return 0;
    if (pre || k < 0 || k > FULL) return FULL;
    return k;
  endfunction

  function automatic string req_of(bit h, int k, bit pre);
    if (!h) return "R6";
    if (pre || k < 0 || k > FULL) return "R5";
    return glitch ? "R4" : "R3";
  endfunction

  task automatic check_codes(input string tag);
    for (int i = 0; i < N; i++) begin
      int aq = int'(code_q[i*W +: W]);
      int at = int'(code_t[i*W +: W]);
      int eq = exp_code(hit[i], kq[i], pre_q[i]);
      int et = exp_code(hit[i], kt[i], pre_t[i]);
      chk(aq == eq, tag == "" ? req_of(hit[i], kq[i], pre_q[i]) : tag,
          $sformatf("charge code ch%0d", i), aq, eq);
      chk(at == et, tag == "" ? req_of(hit[i], kt[i], pre_t[i]) : tag,
          $sformatf("time code ch%0d", i), at, et);
    end
  endtask

  // one conversion: start accepted at edge E0, cycle c lies between E0+c and E0+c+1
  task automatic run_conv();
    int ramp_bad = -1, busy_bad = -1, done_bad = -1;
    logic [N*W-1:0] held_q, held_t;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cq[i] = pre_q[i];
      ct[i] = pre_t[i];
    end
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 4100; c++) begin
      @(negedge clk);
      start = mid_start && (c == 1000 || c == 4097);
      for (int i = 0; i < N; i++) begin
        cq[i] = in_val(kq[i], pre_q[i], c);
        ct[i] = in_val(kt[i], pre_t[i], c);
      end
      if (ramp_bad < 0 && ramp != (c == 0)) ramp_bad = c;
      if (busy_bad < 0 && busy != (c <= 4097)) busy_bad = c;
      if (done_bad < 0 && done != (c == 4098)) done_bad = c;
      if (c == 4098) check_codes("");
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    chk(ramp_bad < 0, mid_start ? "R8" : "R2", "ramp reset wrong at cycle", ramp_bad, -1);
    chk(busy_bad < 0, mid_start ? "R8" : "R2", "busy wrong at cycle", busy_bad, -1);
    chk(done_bad < 0, "R7", "done wrong at cycle", done_bad, -1);
    // codes must hold while comparators keep toggling after done
    held_q = code_q;
    held_t = code_t;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      cq = ~cq;
      ct = ~ct;
    end
    @(negedge clk);
    chk(code_q == held_q && code_t == held_t, "R7", "codes changed after done",
        int'(code_q != held_q) + int'(code_t != held_t), 0);
    cq = '0;
    ct = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_plan();
    glitch = 1'b0;
    mid_start = 1'b0;
    for (int i = 0; i < N; i++) begin
      kq[i] = -1; kt[i] = -1; pre_q[i] = 1'b0; pre_t[i] = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(!ramp, "R1", "ramp reset after reset", ramp, 0);
    chk(code_q == '0 && code_t == '0, "R1", "codes after reset",
        int'(code_q != '0) + int'(code_t != '0), 0);
  endtask

  task automatic t_basic();
    clear_plan();
    hit = '1;
    for (int i = 0; i < N; i++) begin
      kq[i] = i * 211;
      kt[i] = FULL - i * 173;
    end
    kq[1] = kt[1];  // same instant on both inputs of one channel
    run_conv();     // R3: edges at 0 and 4095 included
  endtask

  task automatic t_mask();
    clear_plan();
    hit = 16'hA5C3;
    for (int i = 0; i < N; i++) begin
      kq[i] = 50 + i * 97;
      kt[i] = 3000 - i * 61;
    end
    run_conv();     // R6 on masked channels, R3 on the rest
  endtask

  task automatic t_no_edge();
    clear_plan();
    hit = '1;
    for (int i = 0; i < N; i++) begin
      kq[i] = (i % 4 == 0) ? -1 : (i % 4 == 1) ? 4096 : 100 + i;
      kt[i] = 700 + i * 9;
      pre_q[i] = (i % 4 == 2);
      pre_t[i] = (i % 3 == 0);
    end
    run_conv();     // R5
  endtask

  task automatic t_glitch();
    clear_plan();
    hit = '1;
    glitch = 1'b1;
    for (int i = 0; i < N; i++) begin
      kq[i] = 5 + i * 255;
      kt[i] = 4090 - i * 131;
    end
    run_conv();     // R4
  endtask

  task automatic t_busy_start();
    clear_plan();
    hit = 16'h0FF0;
    mid_start = 1'b1;
    for (int i = 0; i < N; i++) begin
      kq[i] = 900 + i * 13;    // spans the mid-sweep request at cycle 1000
      kt[i] = 2000 + i * 7;
    end
    run_conv();     // R8
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mask();
    t_no_edge();
    t_glitch();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule